// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block decides when the chip resets and how long each phase of a reset lasts. Five hardware causes lead to a full reset that returns every register to its initial value: power-on (the block's own `rst_n`), a long enough low level on the external reset pin, a watchdog expiry, a double bus fault and a lost clock. The processor's reset instruction is a separate, lighter case. It only pulses the reset pin for the benefit of external devices and leaves the core running.

A full reset never cuts a bus transfer in half. A request taken while the processor is running is held until the current operand transfer reports its last portion done, or until the bus monitor reports a timeout. At power-on there is no transfer in flight. The block first waits for the oscillator to be stable for a fixed number of clocks and then declares clock lock. In both cases the block then pulls the reset pin low for a fixed pulse and keeps the internal module reset asserted. After that it releases the pin and watches it. While something outside keeps the pin low, the core stays in reset. Once the pin reads high, the core reset is released, and a fixed number of clocks later a one-clock strobe tells the processor to fetch its stack pointer and program counter.

The reset pin is open-drain. The block only produces an enable that pulls the pin low and never drives it high. Its input side goes through a two-stage synchronizer.

Top module: `rst_seq_top`

## Requirements
- R1: After `rst_n` is released, `clk_locked` rises once `osc_stable` has been high for 328 consecutive clocks. Any clock with `osc_stable` low restarts that count. Until then `rst_pin_oe` is 1 and `core_rst_n` is 0.
- R2: A full reset drives `rst_pin_oe` high for exactly 512 clocks with `core_rst_n` low. This holds after power-on lock and for every hardware cause.
- R3: After the pin drive ends, `core_rst_n` stays low for 3 clocks when the pin reads high. If the pin is held low from outside, `core_rst_n` rises on the third clock after the pin is released.
- R4: `cpu_start` pulses on the 14th clock with `core_rst_n` high, counting the first such clock as 1.
- R5: A one-clock request on `wdog_req`, `dbl_fault_req` or `clk_loss_req` each starts a full reset (R2 to R4) and leaves `clk_locked` at 1.
- R6: While `opnd_done` and `bm_timeout` are both 0, a hardware request changes neither `rst_pin_oe` nor `core_rst_n`. The clock after either one is sampled high, the pin drive and the core reset begin.
- R7: A low level on `rst_pin_in` lasting fewer than 590 consecutive clocks has no effect. One lasting 590 clocks or more starts a full reset.
- R8: A one-clock `sw_reset_req` while running drives `rst_pin_oe` for exactly 512 clocks. `core_rst_n` stays 1, no `cpu_start` follows and `clk_locked` stays 1.
- R9: A hardware request that arrives during a software pin pulse is kept. A full reset starts 3 clocks after that pulse ends.
- R10: `cpu_start` is high for one clock only, and only while `core_rst_n` is 1 and `rst_pin_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| osc_stable | input | 1 | Oscillator/VCO has settled |
| wdog_req | input | 1 | Watchdog expiry request (pulse) |
| dbl_fault_req | input | 1 | Double bus fault request (pulse) |
| clk_loss_req | input | 1 | Loss-of-clock request (pulse) |
| sw_reset_req | input | 1 | Reset instruction executed (pulse) |
| rst_pin_in | input | 1 | Level read back from the reset pin, low = asserted |
| opnd_done | input | 1 | Last portion of current operand transfer completes |
| bm_timeout | input | 1 | Bus monitor has timed out |
| rst_pin_oe | output | 1 | 1 = pull the reset pin low |
| core_rst_n | output | 1 | Internal module reset, active low |
| cpu_start | output | 1 | One-clock strobe that starts the vector fetch |
| clk_locked | output | 1 | Clock lock declared after power-on delay |

## Verification
The pin filter is driven with a table of low-pulse lengths: a single clock, 100, 400, 589, 590 and 591. This separates the one-clock acceptance boundary from short glitches and from mid-length pulses. The full sequence is run from power-on, from each internal hardware cause, and from an external pin that is held low well past the drive pulse. These show that the phase lengths are the same for every cause and that an outside hold stretches only the core-reset phase. The operand gate is tried with both release inputs held low and then freed by one or the other. This shows that the hold-off is real and that either release works. The software pulse is tried on its own and with a watchdog request arriving in the middle, which tells apart a pin-only pulse, a dropped request and a deferred full reset.

// File: rtl/rst_seq_pkg.sv
// Package: shared types and helpers for the reset sequencer.
// Assumes: nothing; pure declarations.
package rst_seq_pkg;

    // Sequencer phases. ST_HOLDX waits while the pin is held low from outside.
    typedef enum logic [3:0] {
        ST_LOCK,
        ST_DRIVE,
        ST_GAP,
        ST_HOLDX,
        ST_START,
        ST_RUN,
        ST_WAIT,
        ST_SWPULSE,
        ST_SWGAP
    } seq_state_e;

    // Number of internal hardware request lines plus the pin filter output.
    localparam int unsigned NUM_HW_SRC = 4;

    // Larger of two counts, used to size the shared phase counter.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rst_pin_filter.sv
// Module: synchronizes the reset pin and accepts a low level only after it
// has lasted MIN_LOW consecutive clocks. Fires one accept pulse per low period.
// Assumes: SYNC_STAGES >= 2, MIN_LOW >= 1; count_en low clears the filter.
module rst_pin_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_LOW     = 590
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic count_en,
    output logic pin_low_sync,
    output logic accept
);
    localparam int unsigned LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] LAST = LW'(MIN_LOW - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [LW-1:0]          low_cnt_q;
    logic                   fired_q;

    // Synchronizer chain: stage 0 samples the pin, each stage copies the previous.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First stage samples the asynchronous pin level.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= pin_in;
                end
            end else begin : g_next
                // Later stage settles the previous stage's value.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign pin_low_sync = ~sync_q[SYNC_STAGES-1];

    // Low-duration counter: runs while enabled and low, stops once fired.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en || !pin_low_sync) begin
            low_cnt_q <= '0;
            fired_q   <= 1'b0;
        end else if (!fired_q) begin
            if (low_cnt_q == LAST) fired_q <= 1'b1;
            else                   low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign accept = count_en & pin_low_sync & ~fired_q & (low_cnt_q == LAST);

endmodule

// File: rtl/rst_req_latch.sv
// Module: holds each hardware reset request until the sequencer takes it.
// Assumes: requests are single-clock pulses; clr wins over a new request.
module rst_req_latch #(
    parameter int unsigned NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic            clr,
    output logic            pend_any
);
    logic [NSRC-1:0] pend_q;

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            // Per-source sticky flag, cleared when a full reset is under way.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) pend_q[s] <= 1'b0;
                else if (req[s])   pend_q[s] <= 1'b1;
            end
        end
    endgenerate

    assign pend_any = |(pend_q | req);

endmodule

// File: rtl/rst_seq_fsm.sv
// Module: phase controller with one shared down counter. Times the power-on
// lock delay, the pin drive, the release gap, the external hold, the fetch
// delay and the software pin pulse, and gates full resets on operand end.
// Assumes: all cycle parameters >= 1; pin_low_sync comes from a synchronizer.
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES  = 328,
    parameter int unsigned HOLD_CYCLES  = 512,
    parameter int unsigned SW_CYCLES    = 512,
    parameter int unsigned GAP_CYCLES   = 2,
    parameter int unsigned FETCH_CYCLES = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_stable,
    input  logic hw_pend,
    input  logic sw_req,
    input  logic opnd_done,
    input  logic bm_timeout,
    input  logic pin_low_sync,
    output logic pin_oe,
    output logic core_rst_n,
    output logic cpu_start,
    output logic clk_locked,
    output logic clr_pend,
    output logic filt_en
);
    localparam int unsigned MAXC =
        max2(max2(LOCK_CYCLES, HOLD_CYCLES), max2(max2(SW_CYCLES, GAP_CYCLES), FETCH_CYCLES));
    localparam int unsigned CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] L_LOCK  = CW'(LOCK_CYCLES - 1);
    localparam logic [CW-1:0] L_HOLD  = CW'(HOLD_CYCLES - 1);
    localparam logic [CW-1:0] L_SW    = CW'(SW_CYCLES - 1);
    localparam logic [CW-1:0] L_GAP   = CW'(GAP_CYCLES - 1);
    localparam logic [CW-1:0] L_FETCH = CW'(FETCH_CYCLES - 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          lock_q, lock_d;
    logic          take;
    logic          bus_free;
    logic          cnt_zero;

    assign bus_free = opnd_done | bm_timeout;
    assign cnt_zero = (cnt_q == '0);

    // Next-state and counter logic for every phase.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lock_d  = lock_q;
        take    = 1'b0;
        case (state_q)
            ST_LOCK: begin
                if (!osc_stable) begin
                    cnt_d = L_LOCK;
                end else if (cnt_zero) begin
                    state_d = ST_DRIVE;
                    cnt_d   = L_HOLD;
                    lock_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_DRIVE: begin
                if (cnt_zero) begin
                    state_d = ST_GAP;
                    cnt_d   = L_GAP;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt_zero) state_d = ST_HOLDX;
                else          cnt_d   = cnt_q - 1'b1;
            end
            ST_HOLDX: begin
                if (!pin_low_sync) begin
                    state_d = ST_START;
                    cnt_d   = L_FETCH;
                end
            end
            ST_START: begin
                if (cnt_zero) state_d = ST_RUN;
                else          cnt_d   = cnt_q - 1'b1;
            end
            ST_RUN: begin
                if (hw_pend) begin
                    if (bus_free) begin
                        state_d = ST_DRIVE;
                        cnt_d   = L_HOLD;
                        take    = 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end else if (sw_req) begin
                    state_d = ST_SWPULSE;
                    cnt_d   = L_SW;
                end
            end
            ST_WAIT: begin
                if (bus_free) begin
                    state_d = ST_DRIVE;
                    cnt_d   = L_HOLD;
                    take    = 1'b1;
                end
            end
            ST_SWPULSE: begin
                if (cnt_zero) begin
                    state_d = ST_SWGAP;
                    cnt_d   = L_GAP;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_SWGAP: begin
                if (cnt_zero) state_d = ST_RUN;
                else          cnt_d   = cnt_q - 1'b1;
            end
            default: begin
                state_d = ST_LOCK;
                cnt_d   = L_LOCK;
            end
        endcase
    end

    // State, counter and lock registers; power-on enters the lock wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCK;
            cnt_q   <= L_LOCK;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lock_q  <= lock_d;
        end
    end

    assign pin_oe     = (state_q == ST_LOCK) || (state_q == ST_DRIVE) || (state_q == ST_SWPULSE);
    assign core_rst_n = !((state_q == ST_LOCK) || (state_q == ST_DRIVE) ||
                          (state_q == ST_GAP)  || (state_q == ST_HOLDX));
    assign cpu_start  = (state_q == ST_START) && cnt_zero;
    assign clk_locked = lock_q;
    assign clr_pend   = take || (state_q == ST_LOCK) || (state_q == ST_DRIVE);
    assign filt_en    = (state_q == ST_RUN) || (state_q == ST_WAIT);

endmodule

// File: rtl/rst_seq_top.sv
// Module: top of the reset sequencer. Joins the pin filter, the request latch
// and the phase controller. The reset pin is open-drain: only a pull-low enable.
// Assumes: request inputs are synchronous to clk; rst_n is the power-on reset.
module rst_seq_top #(
    parameter int unsigned LOCK_CYCLES  = 328,
    parameter int unsigned HOLD_CYCLES  = 512,
    parameter int unsigned SW_CYCLES    = 512,
    parameter int unsigned GAP_CYCLES   = 2,
    parameter int unsigned FETCH_CYCLES = 14,
    parameter int unsigned EXT_MIN_LOW  = 590,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_stable,
    input  logic wdog_req,
    input  logic dbl_fault_req,
    input  logic clk_loss_req,
    input  logic sw_reset_req,
    input  logic rst_pin_in,
    input  logic opnd_done,
    input  logic bm_timeout,
    output logic rst_pin_oe,
    output logic core_rst_n,
    output logic cpu_start,
    output logic clk_locked
);
    import rst_seq_pkg::*;

    logic                  pin_low_sync;
    logic                  ext_accept;
    logic                  filt_en;
    logic                  clr_pend;
    logic                  hw_pend;
    logic [NUM_HW_SRC-1:0] hw_req;

    assign hw_req = {ext_accept, clk_loss_req, dbl_fault_req, wdog_req};

    rst_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_LOW     (EXT_MIN_LOW)
    ) u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_in       (rst_pin_in),
        .count_en     (filt_en),
        .pin_low_sync (pin_low_sync),
        .accept       (ext_accept)
    );

    rst_req_latch #(
        .NSRC (NUM_HW_SRC)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (hw_req),
        .clr      (clr_pend),
        .pend_any (hw_pend)
    );

    rst_seq_fsm #(
        .LOCK_CYCLES  (LOCK_CYCLES),
        .HOLD_CYCLES  (HOLD_CYCLES),
        .SW_CYCLES    (SW_CYCLES),
        .GAP_CYCLES   (GAP_CYCLES),
        .FETCH_CYCLES (FETCH_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_stable   (osc_stable),
        .hw_pend      (hw_pend),
        .sw_req       (sw_reset_req),
        .opnd_done    (opnd_done),
        .bm_timeout   (bm_timeout),
        .pin_low_sync (pin_low_sync),
        .pin_oe       (rst_pin_oe),
        .core_rst_n   (core_rst_n),
        .cpu_start    (cpu_start),
        .clk_locked   (clk_locked),
        .clr_pend     (clr_pend),
        .filt_en      (filt_en)
    );

endmodule

// File: rtl/rst_seq_chk.sv
// Module: checker bound to rst_seq_top. Long windows are measured with
// counters here, not with deep $past.
// Assumes: observes top-level ports only.
module rst_seq_chk #(
    parameter int unsigned LOCK_CYCLES  = 328,
    parameter int unsigned HOLD_CYCLES  = 512,
    parameter int unsigned SW_CYCLES    = 512,
    parameter int unsigned FETCH_CYCLES = 14
) (
    input logic clk,
    input logic rst_n,
    input logic osc_stable,
    input logic opnd_done,
    input logic bm_timeout,
    input logic rst_pin_oe,
    input logic core_rst_n,
    input logic cpu_start,
    input logic clk_locked
);
    logic [15:0] stab_cnt;
    logic [15:0] drv_cnt;
    logic [15:0] up_cnt;

    // Consecutive stable-oscillator clocks before lock.
    always_ff @(posedge clk) begin
        if (!rst_n)           stab_cnt <= '0;
        else if (!clk_locked) stab_cnt <= osc_stable ? stab_cnt + 1'b1 : '0;
    end

    // Length of the current pin drive after lock.
    always_ff @(posedge clk) begin
        if (!rst_n)                        drv_cnt <= '0;
        else if (rst_pin_oe && clk_locked) drv_cnt <= drv_cnt + 1'b1;
        else                               drv_cnt <= '0;
    end

    // Clocks since core reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_rst_n) up_cnt <= '0;
        else if (up_cnt != '1)     up_cnt <= up_cnt + 1'b1;
    end

    assert_lock_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_locked) |-> (stab_cnt == 16'(LOCK_CYCLES)));

    assert_drive_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_pin_oe) && clk_locked) |->
            (drv_cnt == 16'(HOLD_CYCLES) || drv_cnt == 16'(SW_CYCLES)));

    assert_core_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> !rst_pin_oe);

    assert_start_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |-> (up_cnt == 16'(FETCH_CYCLES - 1)));

    assert_core_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_n) |-> rst_pin_oe);

    assert_opnd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_rst_n) && clk_locked) |-> $past(opnd_done || bm_timeout));

    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |=> !cpu_start);

    assert_start_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |-> (core_rst_n && !rst_pin_oe));

endmodule

bind rst_seq_top rst_seq_chk #(
    .LOCK_CYCLES  (LOCK_CYCLES),
    .HOLD_CYCLES  (HOLD_CYCLES),
    .SW_CYCLES    (SW_CYCLES),
    .FETCH_CYCLES (FETCH_CYCLES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_stable (osc_stable),
    .opnd_done  (opnd_done),
    .bm_timeout (bm_timeout),
    .rst_pin_oe (rst_pin_oe),
    .core_rst_n (core_rst_n),
    .cpu_start  (cpu_start),
    .clk_locked (clk_locked)
);

// File: tb/rst_seq_top_tb_top.sv
// Bench: table of external pin pulse lengths, then directed sequences.
module rst_seq_top_tb_top;
    localparam int EXP_LOCK  = 328;
    localparam int EXP_HOLD  = 512;
    localparam int EXP_GAP   = 3;
    localparam int EXP_FETCH = 14;
    localparam int NTAB = 6;
    // {low length, accepted}
    localparam int EXT_TAB [NTAB][2] = '{'{1,0}, '{100,0}, '{589,0}, '{590,1}, '{591,1}, '{400,0}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_stable = 1'b0;
    logic wdog_req = 1'b0, dbl_fault_req = 1'b0, clk_loss_req = 1'b0, sw_reset_req = 1'b0;
    logic ext_low = 1'b0;
    logic opnd_done = 1'b1, bm_timeout = 1'b0;
    logic rst_pin_in;
    logic rst_pin_oe, core_rst_n, cpu_start, clk_locked;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // Wired-AND model of the open-drain pin.
    assign rst_pin_in = ~(ext_low | rst_pin_oe);

    rst_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .osc_stable(osc_stable),
        .wdog_req(wdog_req), .dbl_fault_req(dbl_fault_req), .clk_loss_req(clk_loss_req),
        .sw_reset_req(sw_reset_req), .rst_pin_in(rst_pin_in),
        .opnd_done(opnd_done), .bm_timeout(bm_timeout),
        .rst_pin_oe(rst_pin_oe), .core_rst_n(core_rst_n),
        .cpu_start(cpu_start), .clk_locked(clk_locked));

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Wait up to lim negedges for the pin drive; seen=1 if it appears.
    task automatic wait_oe(input int lim, output int seen);
        seen = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (rst_pin_oe) begin seen = 1; break; end
        end
    endtask

    // One-clock pulse on a request line chosen by sel.
    task automatic pulse_req(input int sel);
        @(negedge clk);
        case (sel)
            0: wdog_req = 1'b1;
            1: dbl_fault_req = 1'b1;
            2: clk_loss_req = 1'b1;
            default: sw_reset_req = 1'b1;
        endcase
        @(negedge clk);
        wdog_req = 1'b0; dbl_fault_req = 1'b0; clk_loss_req = 1'b0; sw_reset_req = 1'b0;
    endtask

    // From the first negedge with the pin driven: drive, release gap, fetch delay.
    task automatic expect_full_seq(input string req);
        int n;
        check_eq(req, "core reset at drive start", core_rst_n, 0);
        n = 0;
        while (rst_pin_oe && n < 5000) begin n++; @(negedge clk); end
        check_eq("R2", {req, " drive length"}, n, EXP_HOLD);
        n = 0;
        while (!core_rst_n && !rst_pin_oe && n < 100) begin n++; @(negedge clk); end
        check_eq("R3", {req, " release gap"}, n, EXP_GAP);
        n = 1;
        while (!cpu_start && n < 100) begin @(negedge clk); n++; end
        check_eq("R4", {req, " fetch delay"}, n, EXP_FETCH);
        @(negedge clk);
        check_eq("R10", {req, " start one clock"}, cpu_start, 0);
        check_eq("R5", {req, " lock kept"}, clk_locked, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n, seen, core_min;
        // Reset state (R1)
        osc_stable = 1'b1;
        repeat (4) @(negedge clk);
        check_eq("R1", "reset pin drive", rst_pin_oe, 1);
        check_eq("R1", "reset core", core_rst_n, 0);
        check_eq("R1", "reset lock", clk_locked, 0);
        check_eq("R10", "reset start", cpu_start, 0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        osc_stable = 1'b0;
        repeat (10) @(negedge clk);
        check_eq("R1", "no lock before delay", clk_locked, 0);
        osc_stable = 1'b1;
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end while (!clk_locked && n < 2000);
        check_eq("R1", "lock delay after restart", n, EXP_LOCK);
        check_eq("R1", "pin driven at lock", rst_pin_oe, 1);
        expect_full_seq("R1 power-on");

        // R7 table of external pulse lengths
        for (int i = 0; i < NTAB; i++) begin
            repeat (10) @(negedge clk);
            ext_low = 1'b1;
            repeat (EXT_TAB[i][0]) @(negedge clk);
            ext_low = 1'b0;
            wait_oe(10, seen);
            check_eq("R7", $sformatf("pulse %0d accepted", EXT_TAB[i][0]), seen, EXT_TAB[i][1]);
            if (seen) expect_full_seq("R7");
            else check_eq("R7", "core after ignored pulse", core_rst_n, 1);
        end

        // R5 each internal cause
        for (int s = 0; s < 3; s++) begin
            repeat (20) @(negedge clk);
            pulse_req(s);
            check_eq("R5", $sformatf("cause %0d drive next clock", s), rst_pin_oe, 1);
            expect_full_seq("R5");
        end

        // R6 hold-off until operand end, released by bus timeout then operand done
        for (int s = 0; s < 2; s++) begin
            repeat (20) @(negedge clk);
            opnd_done = 1'b0;
            pulse_req(s + 1);
            core_min = 1; seen = 0;
            repeat (30) begin
                @(negedge clk);
                if (rst_pin_oe) seen = 1;
                if (!core_rst_n) core_min = 0;
            end
            check_eq("R6", "no drive while transfer open", seen, 0);
            check_eq("R6", "core kept while transfer open", core_min, 1);
            if (s == 0) bm_timeout = 1'b1; else opnd_done = 1'b1;
            @(negedge clk);
            bm_timeout = 1'b0; opnd_done = 1'b1;
            check_eq("R6", "drive after release", rst_pin_oe, 1);
            expect_full_seq("R6");
        end

        // R8 software pulse alone
        repeat (20) @(negedge clk);
        pulse_req(3);
        core_min = 1; seen = 0; n = 0;
        while (rst_pin_oe && n < 5000) begin
            n++;
            if (!core_rst_n) core_min = 0;
            if (cpu_start) seen = 1;
            @(negedge clk);
        end
        check_eq("R8", "sw pulse length", n, EXP_HOLD);
        repeat (40) begin
            @(negedge clk);
            if (!core_rst_n) core_min = 0;
            if (cpu_start || rst_pin_oe) seen = 1;
        end
        check_eq("R8", "sw core untouched", core_min, 1);
        check_eq("R8", "sw no start or repeat", seen, 0);
        check_eq("R8", "sw lock kept", clk_locked, 1);

        // R9 hardware request during software pulse
        repeat (20) @(negedge clk);
        pulse_req(3);
        repeat (100) @(negedge clk);
        pulse_req(0);
        core_min = 1;
        while (rst_pin_oe) begin if (!core_rst_n) core_min = 0; @(negedge clk); end
        check_eq("R9", "core kept during sw pulse", core_min, 1);
        n = 0;
        while (!rst_pin_oe && n < 50) begin n++; @(negedge clk); end
        check_eq("R9", "deferred reset gap", n, 3);
        expect_full_seq("R9");

        // R3 pin held low from outside beyond the drive
        repeat (20) @(negedge clk);
        ext_low = 1'b1;
        wait_oe(700, seen);
        check_eq("R3", "held pin accepted", seen, 1);
        while (rst_pin_oe) @(negedge clk);
        repeat (50) @(negedge clk);
        check_eq("R3", "core held by external pin", core_rst_n, 0);
        check_eq("R3", "pin released by block", rst_pin_oe, 0);
        ext_low = 1'b0;
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end while (!core_rst_n && n < 50);
        check_eq("R3", "core release after pin release", n, 3);
        n = 1;
        while (!cpu_start && n < 100) begin @(negedge clk); n++; end
        check_eq("R4", "fetch delay after hold", n, EXP_FETCH);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule